// File: doc/BRIEF.md
# Cycle-Paced SPI Master

This block is a single-slave SPI master in which the serial clock, chip select and data-out lines are plain flip-flops updated by a state machine running on one fast pacer clock. No second clock and no gated clock exist: every phase of the serial waveform is a counted number of pacer cycles, so the output waveform is known exactly in pacer cycles. A one-cycle start pulse from surrounding logic launches a transfer of one word. The word is shifted out MSB first while the slave's reply is shifted in. A done pulse then presents the received word.

The serial clock idles low. The chip select falls together with the first data bit. A lead interval follows before the first rising edge. The master samples the input line on every rising edge, which is the middle of the data eye, and changes the output line on every falling edge. After the last bit a final low interval passes and then the chip select rises.

The controller has five states. IDLE goes to LEAD on start. LEAD goes to HIGH when the lead count expires, and this raises SCK. HIGH goes to LOW when the high count expires, unless the final bit is in flight; in that case it goes to TAIL. LOW goes back to HIGH when the low count expires. TAIL goes to IDLE when its low count expires.

Top module: `spi_pacer_master`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and `done` is 0.
- R2: A `start` pulse sampled while idle makes `spi_cs_n` 0, `busy` 1 and `spi_mosi` equal to bit WORD_W-1 of `tx_word`, all at the next clock edge.
- R3: `spi_sck` first rises exactly LEAD_CYC pacer cycles after `spi_cs_n` falls.
- R4: Each `spi_sck` high phase lasts HIGH_CYC cycles. Each low phase between bits lasts LOW_CYC cycles. Exactly WORD_W rising edges occur per transfer.
- R5: Data leaves MSB first (bit WORD_W-1 first, bit 0 last). While `spi_cs_n` is low, `spi_mosi` changes only at the edge where `spi_sck` falls, and it holds the last bit after the final falling edge.
- R6: `spi_miso` is sampled at each edge where `spi_sck` rises. The first sampled bit becomes bit WORD_W-1 of `rx_word`.
- R7: `spi_cs_n` returns to 1 exactly LOW_CYC cycles after the final falling edge of `spi_sck`. At that same edge `done` is 1 for one cycle, `busy` becomes 0 and `rx_word` holds the received word.
- R8: A `start` pulse while `busy` is 1 is ignored. The waveform, the transmitted bits and the transfer length are unchanged, even if `tx_word` changes at the same time.
- R9: A `start` pulse in the cycle where `done` is 1 is accepted, so the next transfer begins at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pacer clock; all phases are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_word | input | WORD_W | Word to send, sampled with an accepted start |
| rx_word | output | WORD_W | Word received, valid from the done pulse on |
| busy | output | 1 | High from the edge after start until the done edge |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| spi_cs_n | output | 1 | Active-low chip select, registered |
| spi_sck | output | 1 | Serial clock, registered, idles low |
| spi_mosi | output | 1 | Serial data out, registered |
| spi_miso | input | 1 | Serial data in from the slave |

## Verification
The embedded assertions check on every cycle that the clock stays low while the chip select is high. They also check that the chip select only falls from idle, that the data line only moves on a falling clock edge, and that done is a single idle-state pulse. The exact phase lengths in pacer cycles, the MSB-first order on both lines and the received word can only be shown by the bench. It uses a cycle-by-cycle reference of the whole pin waveform with a slave that answers on the input line. The bench's scenarios also cover ignored mid-transfer starts and back-to-back transfers.

// File: rtl/spi_pacer_pkg.sv
package spi_pacer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } spi_state_e;

endpackage

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              sample,
    input  logic              miso_in,
    output logic              mosi_out,
    output logic [WORD_W-1:0] rx_shift
);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_word;
        end else if (shift) begin
            tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample) begin
            rx_sr <= {rx_sr[WORD_W-2:0], miso_in};
        end
    end

    assign mosi_out = tx_sr[WORD_W-1];
    assign rx_shift = rx_sr;

endmodule

// File: rtl/spi_pacer_master.sv
module spi_pacer_master
    import spi_pacer_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int LEAD_CYC = 10,
    parameter int HIGH_CYC = 10,
    parameter int LOW_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int MAX_LH = (LEAD_CYC > HIGH_CYC) ? LEAD_CYC : HIGH_CYC;
    localparam int MAX_C  = (MAX_LH > LOW_CYC) ? MAX_LH : LOW_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_B = BIT_W'(WORD_W - 1);

    spi_state_e state_q, state_d;

    logic             ph_load;
    logic [CNT_W-1:0] ph_val;
    logic             ph_done;
    logic [BIT_W-1:0] bit_q;
    logic             last_bit;
    logic             ev_start, ev_rise, ev_fall, ev_end;
    logic [WORD_W-1:0] rx_shift;

    assign last_bit = (bit_q == LAST_B);

    // next-state and event decode
    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        ev_start = 1'b0;
        ev_rise  = 1'b0;
        ev_fall  = 1'b0;
        ev_end   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_LEAD;
                    ph_load  = 1'b1;
                    ph_val   = LEAD_V;
                    ev_start = 1'b1;
                end
            end
            ST_LEAD: begin
                if (ph_done) begin
                    state_d = ST_HIGH;
                    ph_load = 1'b1;
                    ph_val  = HIGH_V;
                    ev_rise = 1'b1;
                end
            end
            ST_HIGH: begin
                if (ph_done) begin
                    state_d = last_bit ? ST_TAIL : ST_LOW;
                    ph_load = 1'b1;
                    ph_val  = LOW_V;
                    ev_fall = 1'b1;
                end
            end
            ST_LOW: begin
                if (ph_done) begin
                    state_d = ST_HIGH;
                    ph_load = 1'b1;
                    ph_val  = HIGH_V;
                    ev_rise = 1'b1;
                end
            end
            ST_TAIL: begin
                if (ph_done) begin
                    state_d = ST_IDLE;
                    ev_end  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (ev_start) begin
            bit_q <= '0;
        end else if (ev_fall && !last_bit) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // registered pin and status outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_cs_n <= 1'b1;
            spi_sck  <= 1'b0;
            done     <= 1'b0;
            rx_word  <= '0;
        end else begin
            done <= ev_end;
            if (ev_start) begin
                spi_cs_n <= 1'b0;
            end else if (ev_end) begin
                spi_cs_n <= 1'b1;
                rx_word  <= rx_shift;
            end
            if (ev_rise) begin
                spi_sck <= 1'b1;
            end else if (ev_fall) begin
                spi_sck <= 1'b0;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

    spi_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_done)
    );

    spi_shift_unit #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ev_start),
        .load_word (tx_word),
        .shift     (ev_fall && !last_bit),
        .sample    (ev_rise),
        .miso_in   (spi_miso),
        .mosi_out  (spi_mosi),
        .rx_shift  (rx_shift)
    );

    // R1: idle pins
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sck));

    // R3, R4: clock only toggles inside a selected frame
    p_sck_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R8: select only falls out of idle
    p_cs_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !$past(busy));

    // R5: data moves only on a falling serial clock edge
    p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(spi_mosi) && !spi_cs_n && !$past(spi_cs_n)) |-> $fell(spi_sck));

    // R7: done is a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done coincides with a released select and idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !busy && !spi_sck));

endmodule

// File: tb/spi_pacer_master_tb.sv
`timescale 1ns/1ps
module spi_pacer_master_tb;

    localparam int W    = 8;
    localparam int LEAD = 5;
    localparam int HI   = 3;
    localparam int LO   = 4;
    localparam int PER  = HI + LO;
    localparam int TOTAL = LEAD + W * PER;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic [W-1:0] rx_word;
    logic         busy, done, spi_cs_n, spi_sck, spi_mosi;
    logic         spi_miso = 1'b0;

    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_pacer_master #(
        .WORD_W   (W),
        .LEAD_CYC (LEAD),
        .HIGH_CYC (HI),
        .LOW_CYC  (LO)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tx_word  (tx_word),
        .rx_word  (rx_word),
        .busy     (busy),
        .done     (done),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // bit index on both data lines, p cycles after the start edge
    function automatic int bit_pos(input int p);
        int q, b, r;
        if (p < LEAD) return 0;
        q = p - LEAD;
        b = q / PER;
        r = q % PER;
        if (r < HI) return b;
        return (b + 1 < W) ? b + 1 : W - 1;
    endfunction

    function automatic logic exp_sck(input int p);
        if (p < LEAD) return 1'b0;
        return ((p - LEAD) % PER) < HI;
    endfunction

    // caller is at a negedge; ign_at >= 0 fires an extra start mid-frame
    task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] slv,
                            input int ign_at, input string tag);
        start   = 1'b1;
        tx_word = tx;
        spi_miso = slv[W-1];
        for (int p = 0; p <= TOTAL; p++) begin
            @(negedge clk);
            start = (p == ign_at);
            if (p == ign_at) tx_word = ~tx;
            if (p < TOTAL) begin
                chk({tag, " R2 R7 cs_n"}, spi_cs_n, 1'b0);
                chk({tag, " R3 R4 sck"}, spi_sck, exp_sck(p));
                chk({tag, " R5 mosi"}, spi_mosi, tx[W-1-bit_pos(p)]);
                chk({tag, " R2 R8 busy"}, busy, 1'b1);
                chk({tag, " R7 done"}, done, 1'b0);
                spi_miso = slv[W-1-bit_pos(p)];
            end else begin
                chk({tag, " R7 cs_n end"}, spi_cs_n, 1'b1);
                chk({tag, " R7 sck end"}, spi_sck, 1'b0);
                chk({tag, " R7 done"}, done, 1'b1);
                chk({tag, " R7 busy end"}, busy, 1'b0);
                chk({tag, " R6 rx_word"}, rx_word, slv);
            end
        end
        start = 1'b0;
    endtask

    task automatic idle_check(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk({tag, " R1 cs_n"}, spi_cs_n, 1'b1);
            chk({tag, " R1 sck"}, spi_sck, 1'b0);
            chk({tag, " R1 busy"}, busy, 1'b0);
            chk({tag, " R1 done"}, done, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset cs_n", spi_cs_n, 1'b1);
        chk("R1 reset sck", spi_sck, 1'b0);
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset done", done, 1'b0);
        rst_n = 1'b1;
        idle_check(3, "post-reset");

        run_xfer(8'hA5, 8'h3C, -1, "basic");
        idle_check(2, "gap");
        run_xfer(8'h00, 8'hFF, -1, "zeros");
        idle_check(2, "gap");
        run_xfer(8'hFF, 8'h00, 2, "R8 ignore-in-lead");
        idle_check(2, "gap");
        run_xfer(8'h81, 8'h7E, LEAD + 3, "R8 ignore-in-bits");
        run_xfer(8'h5A, 8'hC3, -1, "R9 back-to-back");
        run_xfer(8'h01, 8'h80, TOTAL - 2, "R9 chained R8 ignore-in-tail");
        idle_check(4, "final");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule